// File: doc/BRIEF.md
# Grouped interrupt priority arbiter

The arbiter takes the state of a set of interrupt sources and decides, for every processor, whether its normal interrupt line or its fast interrupt line must be raised, and which source is currently the most urgent one for that processor. Each source carries pending, enable and group bits, an 8-bit priority and a mask of the processors it targets. Each processor has a priority mask, a running priority and three interface bits: a group 0 enable, a group 1 enable and a fast-routing enable. Two distributor-wide enables, one per group, and a grouping-mode select complete the inputs.

A single scanner steps through the sources, one per clock, and every processor lane keeps its own best candidate during the pass. When the pass ends, each lane turns its winner into a line decision: the winner's group picks the line, and both the distributor enables and the interface enables gate delivery. Every lane is judged on its own, so a processor whose interface is shut off has no effect on the others. Any change on any input throws away the pass in progress and starts a new one from source 0.

Top module: `grp_prio_arb`

## Requirements
- R1: While reset is asserted and until the first completed scan, every irq_o and fiq_o bit is 0 and every cur_id_o entry is 1023.
- R2: For each processor the winner is the source with the lowest priority value among the sources that are enabled, pending and whose src_tgt bit for that processor is 1; on equal priority the lower source number wins.
- R3: The winner's number is reported in cur_id_o only if its priority is strictly below cpu_pmask; otherwise cur_id_o is 1023 and neither line is raised. With no candidate, cur_id_o is 1023.
- R4: A reported winner raises a line only if its group is enabled at the distributor (dist_g0en for group 0, dist_g1en for group 1) and its priority is strictly below cpu_run; otherwise the ID is still reported with both lines low.
- R5: A signalled group 0 winner (src_grp 0) drives fiq_o when cpu_fiqen is 1 and drives irq_o when cpu_fiqen is 0, in both cases only if cpu_g0en is 1.
- R6: A signalled group 1 winner (src_grp 1) drives irq_o only if cpu_g1en is 1, and never drives fiq_o.
- R7: If dist_g0en and dist_g1en are both 0, or that processor's cpu_g0en and cpu_g1en are both 0, its irq_o and fiq_o are 0 and its cur_id_o is 1023.
- R8: Each processor is judged separately; a processor disabled by its own interface bits does not change the result of any other processor.
- R9: Grouping is active when ctrl_rev is 2 or more or sec_ext is 1. With grouping inactive, every source is treated as group 0, fast routing is off, and dist_g1en and cpu_g1en are treated as 0.
- R10: Outputs change only at the end of a scan; after the last input change the new outputs appear after NSRC+1 rising clock edges and not earlier, and an input change during a scan restarts it from source 0.
- R11: irq_o and fiq_o are never both 1 for the same processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | NSRC | Pending bit per source |
| src_en | input | NSRC | Enable bit per source |
| src_grp | input | NSRC | Group per source (0 or 1) |
| src_prio | input | NSRC x 8 | Priority per source, lower is more urgent |
| src_tgt | input | NSRC x NCPU | Processor target mask per source |
| cpu_pmask | input | NCPU x 8 | Priority mask per processor |
| cpu_run | input | NCPU x 8 | Running priority per processor |
| cpu_g0en | input | NCPU | Interface group 0 enable per processor |
| cpu_g1en | input | NCPU | Interface group 1 enable per processor |
| cpu_fiqen | input | NCPU | Fast routing of group 0 per processor |
| dist_g0en | input | 1 | Distributor group 0 enable |
| dist_g1en | input | 1 | Distributor group 1 enable |
| ctrl_rev | input | 4 | Controller revision, grouping when 2 or more |
| sec_ext | input | 1 | Security extension present, forces grouping |
| irq_o | output | NCPU | Normal interrupt line per processor |
| fiq_o | output | NCPU | Fast interrupt line per processor |
| cur_id_o | output | NCPU x 10 | Current highest pending ID per processor, 1023 when none |

## Verification
The assertions rely on the inputs being sampled only at rising edges, so an input held for one clock is part of exactly one restart decision; the bench changes inputs only at falling edges. The routing checks compare the registered lines with the inputs present at the update edge, which assumes inputs do not move in the cycle they are captured; the bench keeps them still for at least NSRC+3 cycles before each check, except in the timing scenario, which changes them on purpose mid-scan to exercise the restart.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  localparam int PW  = 8;
  localparam int IDW = 10;
  localparam logic [IDW-1:0] NO_ID   = 10'd1023;
  localparam logic [PW:0]    NO_PRIO = 9'h100;

  typedef struct packed {
    logic [PW:0]    prio;
    logic [IDW-1:0] id;
    logic           grp;
  } cand_t;

  typedef struct packed {
    logic           irq;
    logic           fiq;
    logic [IDW-1:0] id;
  } verdict_t;

  function automatic logic grouping_on(input logic [3:0] rev, input logic sec);
    return (rev >= 4'd2) || sec;
  endfunction

  // strict compare: an earlier (lower numbered) source keeps a tie
  function automatic cand_t pick(input cand_t best, input cand_t cur, input logic ok);
    if (ok && (cur.prio < best.prio)) return cur;
    return best;
  endfunction

  function automatic verdict_t judge(input cand_t w, input logic [PW-1:0] pmask,
                                     input logic [PW-1:0] run, input logic dg0,
                                     input logic dg1, input logic cg0, input logic cg1,
                                     input logic fiqen);
    verdict_t v;
    v     = '0;
    v.id  = NO_ID;
    if ((dg0 || dg1) && (cg0 || cg1) && (w.prio < {1'b0, pmask})) begin
      v.id = w.id;
      if ((w.grp ? dg1 : dg0) && (w.prio < {1'b0, run})) begin
        if (!w.grp) begin
          if (fiqen) v.fiq = cg0;
          else       v.irq = cg0;
        end else begin
          v.irq = cg1;
        end
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/gpa_scan_ctl.sv
module gpa_scan_ctl #(
  parameter int NSRC  = 8,
  parameter int SNAPW = 16,
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SNAPW-1:0] snap_in,
  output logic [SW-1:0]    idx,
  output logic             restart,
  output logic             upd
);
  localparam logic [SW-1:0] LAST = SW'(NSRC - 1);

  logic [SNAPW-1:0] snap_q;

  assign restart = (snap_in != snap_q);
  assign upd     = (idx == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      idx    <= '0;
    end else begin
      snap_q <= snap_in;
      if (restart || (idx == LAST)) idx <= '0;
      else                          idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/gpa_lane.sv
module gpa_lane
  import gpa_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           upd,
  input  cand_t          cur,
  input  logic           cur_ok,
  input  logic [PW-1:0]  pmask,
  input  logic [PW-1:0]  run,
  input  logic           dg0,
  input  logic           dg1,
  input  logic           cg0,
  input  logic           cg1,
  input  logic           fiqen,
  output logic           irq,
  output logic           fiq,
  output logic [IDW-1:0] id
);
  cand_t    best_q, best_nx;
  verdict_t verdict;

  assign best_nx = pick(best_q, cur, cur_ok);
  assign verdict = judge(best_nx, pmask, run, dg0, dg1, cg0, cg1, fiqen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q <= '{prio: NO_PRIO, id: NO_ID, grp: 1'b0};
      irq    <= 1'b0;
      fiq    <= 1'b0;
      id     <= NO_ID;
    end else if (restart) begin
      best_q <= '{prio: NO_PRIO, id: NO_ID, grp: 1'b0};
    end else if (upd) begin
      best_q <= '{prio: NO_PRIO, id: NO_ID, grp: 1'b0};
      irq    <= verdict.irq;
      fiq    <= verdict.fiq;
      id     <= verdict.id;
    end else begin
      best_q <= best_nx;
    end
  end
endmodule

// File: rtl/grp_prio_arb.sv
module grp_prio_arb
  import gpa_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int NCPU = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           src_pend,
  input  logic [NSRC-1:0]           src_en,
  input  logic [NSRC-1:0]           src_grp,
  input  logic [NSRC-1:0][7:0]      src_prio,
  input  logic [NSRC-1:0][NCPU-1:0] src_tgt,
  input  logic [NCPU-1:0][7:0]      cpu_pmask,
  input  logic [NCPU-1:0][7:0]      cpu_run,
  input  logic [NCPU-1:0]           cpu_g0en,
  input  logic [NCPU-1:0]           cpu_g1en,
  input  logic [NCPU-1:0]           cpu_fiqen,
  input  logic                      dist_g0en,
  input  logic                      dist_g1en,
  input  logic [3:0]                ctrl_rev,
  input  logic                      sec_ext,
  output logic [NCPU-1:0]           irq_o,
  output logic [NCPU-1:0]           fiq_o,
  output logic [NCPU-1:0][9:0]      cur_id_o
);
  localparam int SW    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int SNAPW = NSRC * (3 + PW + NCPU) + NCPU * (2 * PW + 3) + 2 + 4 + 1;

  logic [SNAPW-1:0] snap_vec;
  logic [SW-1:0]    scan_idx;
  logic             restart;
  logic             scan_upd;
  logic             grouping;
  cand_t            cur;

  assign snap_vec = {src_pend, src_en, src_grp, src_prio, src_tgt, cpu_pmask, cpu_run,
                     cpu_g0en, cpu_g1en, cpu_fiqen, dist_g0en, dist_g1en, ctrl_rev, sec_ext};

  gpa_scan_ctl #(.NSRC(NSRC), .SNAPW(SNAPW)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap_in (snap_vec),
    .idx     (scan_idx),
    .restart (restart),
    .upd     (scan_upd)
  );

  assign grouping = grouping_on(ctrl_rev, sec_ext);
  assign cur.prio = {1'b0, src_prio[scan_idx]};
  assign cur.id   = IDW'(scan_idx);
  assign cur.grp  = grouping & src_grp[scan_idx];

  for (genvar c = 0; c < NCPU; c++) begin : g_lane
    logic cur_ok;
    assign cur_ok = src_en[scan_idx] & src_pend[scan_idx] & src_tgt[scan_idx][c];

    gpa_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .upd     (scan_upd),
      .cur     (cur),
      .cur_ok  (cur_ok),
      .pmask   (cpu_pmask[c]),
      .run     (cpu_run[c]),
      .dg0     (dist_g0en),
      .dg1     (dist_g1en & grouping),
      .cg0     (cpu_g0en[c]),
      .cg1     (cpu_g1en[c] & grouping),
      .fiqen   (cpu_fiqen[c] & grouping),
      .irq     (irq_o[c]),
      .fiq     (fiq_o[c]),
      .id      (cur_id_o[c])
    );
  end
endmodule

// File: rtl/gpa_chk.sv
module gpa_chk #(
  parameter int NSRC = 8,
  parameter int NCPU = 2,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCPU-1:0]      cpu_g0en,
  input logic [NCPU-1:0]      cpu_fiqen,
  input logic                 dist_g0en,
  input logic                 dist_g1en,
  input logic [NCPU-1:0]      irq_o,
  input logic [NCPU-1:0]      fiq_o,
  input logic [NCPU-1:0][9:0] cur_id_o,
  input logic                 restart,
  input logic                 scan_upd,
  input logic [SW-1:0]        scan_idx
);
  a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & fiq_o) == '0);

  a_r10_hold_between_scans: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_upd |=> ($stable(irq_o) && $stable(fiq_o) && $stable(cur_id_o)));

  a_r10_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (scan_idx == '0));

  a_r7_dist_off: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_upd && !dist_g0en && !dist_g1en) |=>
      (irq_o == '0 && fiq_o == '0 && cur_id_o == {NCPU{10'd1023}}));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    a_r5_fiq_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
      scan_upd |=> (!fiq_o[c] || $past(cpu_fiqen[c] && cpu_g0en[c] && dist_g0en)));

    a_r3_line_has_id: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] || fiq_o[c]) |-> (cur_id_o[c] != 10'd1023));
  end
endmodule

bind grp_prio_arb gpa_chk #(.NSRC(NSRC), .NCPU(NCPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_g0en  (cpu_g0en),
  .cpu_fiqen (cpu_fiqen),
  .dist_g0en (dist_g0en),
  .dist_g1en (dist_g1en),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .cur_id_o  (cur_id_o),
  .restart   (restart),
  .scan_upd  (scan_upd),
  .scan_idx  (scan_idx)
);

// File: tb/tb_grp_prio_arb.sv
`timescale 1ns/1ps
module tb_grp_prio_arb;
  localparam int NSRC = 8;
  localparam int NCPU = 2;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [NSRC-1:0]           src_pend, src_en, src_grp;
  logic [NSRC-1:0][7:0]      src_prio;
  logic [NSRC-1:0][NCPU-1:0] src_tgt;
  logic [NCPU-1:0][7:0]      cpu_pmask, cpu_run;
  logic [NCPU-1:0]           cpu_g0en, cpu_g1en, cpu_fiqen;
  logic                      dist_g0en, dist_g1en, sec_ext;
  logic [3:0]                ctrl_rev;
  logic [NCPU-1:0]           irq_o, fiq_o;
  logic [NCPU-1:0][9:0]      cur_id_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  grp_prio_arb #(.NSRC(NSRC), .NCPU(NCPU)) dut (.*);

  task automatic chk(input int c, input bit ei, input bit ef, input int eid, input string tag);
    total++;
    if (irq_o[c] !== ei || fiq_o[c] !== ef || int'(cur_id_o[c]) != eid) begin
      bad++;
      $display("FAIL %s cpu%0d: irq=%0b fiq=%0b id=%0d expected irq=%0b fiq=%0b id=%0d",
               tag, c, irq_o[c], fiq_o[c], cur_id_o[c], ei, ef, eid);
    end
    total++;
    if (irq_o[c] && fiq_o[c]) begin
      bad++;
      $display("FAIL R11 cpu%0d: irq=1 fiq=1 expected at most one", c);
    end
  endtask

  task automatic settle();
    repeat (NSRC + 3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    src_pend = '0; src_en = '0; src_grp = '0;
    for (int i = 0; i < NSRC; i++) src_prio[i] = 8'h80;
    src_tgt = '1;
    for (int c = 0; c < NCPU; c++) begin
      cpu_pmask[c] = 8'hFF; cpu_run[c] = 8'hFF;
    end
    cpu_g0en = '1; cpu_g1en = '1; cpu_fiqen = '0;
    dist_g0en = 1'b1; dist_g1en = 1'b1; ctrl_rev = 4'd2; sec_ext = 1'b0;
  endtask

  task automatic add_src(input int s, input bit g, input logic [7:0] p);
    src_pend[s] = 1'b1; src_en[s] = 1'b1; src_grp[s] = g; src_prio[s] = p;
  endtask

  task automatic t_reset();
    defaults();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(0, 0, 0, 1023, "R1 reset");
    chk(1, 0, 0, 1023, "R1 reset");
    rst_n = 1'b1;
    settle();
    chk(0, 0, 0, 1023, "R3 no candidate");
  endtask

  task automatic t_select();
    @(negedge clk); defaults();
    add_src(3, 1, 8'h40); add_src(5, 1, 8'h20); add_src(6, 1, 8'h20);
    settle();
    chk(0, 1, 0, 5, "R2 lowest value, tie to lower id");
    chk(1, 1, 0, 5, "R2 lowest value, tie to lower id");
    src_en[5] = 1'b0; settle();
    chk(0, 1, 0, 6, "R2 disabled source skipped");
    src_en[5] = 1'b1; src_tgt[5] = 2'b10; settle();
    chk(0, 1, 0, 6, "R2 untargeted source skipped");
    chk(1, 1, 0, 5, "R8 per-cpu target");
    src_pend[6] = 1'b0; settle();
    chk(0, 1, 0, 3, "R2 non-pending source skipped");
  endtask

  task automatic t_mask_run();
    @(negedge clk); defaults();
    add_src(2, 1, 8'h50); cpu_pmask[0] = 8'h50; settle();
    chk(0, 0, 0, 1023, "R3 equal to mask");
    chk(1, 1, 0, 2, "R3 other cpu unmasked");
    cpu_pmask[0] = 8'h51; settle();
    chk(0, 1, 0, 2, "R3 below mask");
    cpu_run[0] = 8'h50; settle();
    chk(0, 0, 0, 2, "R4 equal to running");
    cpu_run[0] = 8'h51; settle();
    chk(0, 1, 0, 2, "R4 below running");
    dist_g1en = 1'b0; settle();
    chk(0, 0, 0, 2, "R4 group disabled at distributor");
  endtask

  task automatic t_group0();
    @(negedge clk); defaults();
    add_src(1, 0, 8'h10); settle();
    chk(0, 1, 0, 1, "R5 group0 to irq");
    cpu_fiqen[0] = 1'b1; settle();
    chk(0, 0, 1, 1, "R5 group0 to fiq");
    chk(1, 1, 0, 1, "R5 other cpu irq");
    cpu_g0en[0] = 1'b0; settle();
    chk(0, 0, 0, 1, "R5 fiq blocked by interface");
    cpu_fiqen[0] = 1'b0; settle();
    chk(0, 0, 0, 1, "R5 irq blocked by interface");
  endtask

  task automatic t_group1();
    @(negedge clk); defaults();
    add_src(1, 1, 8'h10); cpu_fiqen = '1; cpu_g1en[0] = 1'b0; settle();
    chk(0, 0, 0, 1, "R6 group1 blocked by interface");
    cpu_g1en[0] = 1'b1; settle();
    chk(0, 1, 0, 1, "R6 group1 to irq despite fast routing");
  endtask

  task automatic t_disabled();
    @(negedge clk); defaults();
    add_src(1, 1, 8'h10); dist_g0en = 1'b0; dist_g1en = 1'b0; settle();
    chk(0, 0, 0, 1023, "R7 distributor off");
    chk(1, 0, 0, 1023, "R7 distributor off");
    dist_g0en = 1'b1; dist_g1en = 1'b1; cpu_g0en[0] = 1'b0; cpu_g1en[0] = 1'b0; settle();
    chk(0, 0, 0, 1023, "R7 interface off");
    chk(1, 1, 0, 1, "R8 later cpu still delivered");
  endtask

  task automatic t_mode();
    @(negedge clk); defaults();
    add_src(1, 1, 8'h10); cpu_fiqen = '1; ctrl_rev = 4'd1; settle();
    chk(0, 1, 0, 1, "R9 ungrouped: group0, no fast route");
    cpu_g0en[0] = 1'b0; settle();
    chk(0, 0, 0, 1023, "R9 ungrouped ignores interface group1");
    sec_ext = 1'b1; settle();
    chk(0, 1, 0, 1, "R9 security forces grouping");
    sec_ext = 1'b0; cpu_g0en[0] = 1'b1; dist_g0en = 1'b0; settle();
    chk(0, 0, 0, 1023, "R9 ungrouped ignores distributor group1");
  endtask

  task automatic t_timing();
    @(negedge clk); defaults();
    add_src(1, 1, 8'h10); settle();
    chk(0, 1, 0, 1, "R10 baseline");
    src_pend[1] = 1'b0;
    repeat (NSRC) @(posedge clk);
    @(negedge clk);
    chk(0, 1, 0, 1, "R10 not before NSRC+1 edges");
    @(posedge clk); @(negedge clk);
    chk(0, 0, 0, 1023, "R10 at NSRC+1 edges");
    src_pend[1] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    add_src(4, 1, 8'h05);
    repeat (NSRC) @(posedge clk);
    @(negedge clk);
    chk(0, 0, 0, 1023, "R10 restarted scan holds old result");
    @(posedge clk); @(negedge clk);
    chk(0, 1, 0, 4, "R10 result after restart");
  endtask

  initial begin
    t_reset();
    t_select();
    t_mask_run();
    t_group0();
    t_group1();
    t_disabled();
    t_mode();
    t_timing();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule